// File: doc/BRIEF.md
# Pipelined Synchronous Burst SRAM Model

This block is a synthesizable behavioural model of a pipelined synchronous SRAM. Its 32-bit word is split into four byte lanes. An external address controller runs the burst counting and strobe decoding. Each clock it presents the block with a word address, a select flag and a flag that marks the first cycle of an access opened by the processor-side strobe.

The block captures the address, the write controls and the write data on the same rising edge. In the following cycle it either writes the selected byte lanes into the array or reads the word into a registered output stage. A read therefore reaches the data bus one clock after its address was registered. The bus is modelled as a data vector plus a separate drive enable.

A global write strobe overrides the per-byte controls. On the processor-opened first cycle all write controls are ignored and the cycle is treated as a read. The drive enable is forced off during any registered write cycle, whatever the output enable says. A sleep input freezes the block and keeps the bus released.

The array depth is set by `ADDR_W`. Setting `ADDR_W = 17` gives the full 128K-word organisation.

Top module: `sbsram_model`

## Requirements
- R1: A selected, non-sleeping cycle with `proc_start` = 0 and `gw_n` = 0 writes all four lanes of `wdata` to `addr`. `bwe_n` and `bw_n` have no effect on such a cycle.
- R2: With `gw_n` = 1 and `bwe_n` = 0, lane i is written only when `bw_n[i]` = 0. Lane i is bits [8i+7:8i]. Every other lane of the addressed word keeps its old value.
- R3: A selected cycle is a read, and changes no array content, when `gw_n` = 1 and either `bwe_n` = 1 or `bw_n` = 4'b1111.
- R4: A selected cycle with `proc_start` = 1 is a read, whatever `gw_n`, `bwe_n` and `bw_n` say. It writes nothing and delivers the addressed word.
- R5: A read presented before rising edge k drives `dq_out` with `dq_drive` = 1 in the cycle after edge k+1. Consecutive reads deliver one word per clock, in address order, including a wrapped four-word sequence and a repeated (held) address.
- R6: `dq_drive` is 0 in any cycle whose registered access is a write, even when `oe_n` = 0.
- R7: `dq_drive` is 0 whenever `oe_n` = 1, and in the cycle after a deselected cycle has been registered.
- R8: While `sleep` = 1, `sel`, the write controls and `wdata` are ignored: nothing is written and `dq_drive` is 0 from the first edge with `sleep` high. After `sleep` falls, the bus stays released until a new read completes.
- R9: A write followed immediately by a read of the same address returns the newly written word.
- R10: While `rst` = 1, and after it, `dq_drive` is 0 until a read completes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset of pipeline state |
| sleep | input | 1 | Sleep request; while high all other inputs are ignored |
| sel | input | 1 | Cycle is a selected access |
| proc_start | input | 1 | First cycle of a processor-opened access (write controls ignored) |
| addr | input | ADDR_W | Word address of this cycle |
| gw_n | input | 1 | Global write, active low, writes all lanes |
| bwe_n | input | 1 | Byte-write enable, active low |
| bw_n | input | 4 | Per-lane write selects, active low, bit i = lane i |
| oe_n | input | 1 | Output enable, active low |
| wdata | input | 32 | Write data, captured with the address |
| dq_out | output | 32 | Registered read data |
| dq_drive | output | 1 | High when the block drives the data bus |

## Verification
A wrong lane mask in the input stage shows as a corrupted or stale byte. It appears on `dq_out` two clocks after the next read of that address, so every read is compared against a byte-masked reference. A wrong cycle kind in the registered stage shows within one clock as a drive-enable error: a bus driven during a write or during sleep, or a read that never appears. Long pseudo-random sequences over a narrow address window make such errors show up soon after they occur.

// File: rtl/sbsram_pkg.sv
package sbsram_pkg;
  typedef enum logic [1:0] {
    CYC_IDLE  = 2'd0,
    CYC_READ  = 2'd1,
    CYC_WRITE = 2'd2
  } cyc_e;
endpackage

// File: rtl/sbsram_in_stage.sv
module sbsram_in_stage
  import sbsram_pkg::*;
#(
  parameter int ADDR_W = 10,
  parameter int LANES  = 4,
  parameter int LANE_W = 8,
  localparam int DATA_W = LANES * LANE_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sleep,
  input  logic              sel,
  input  logic              proc_start,
  input  logic [ADDR_W-1:0] addr,
  input  logic              gw_n,
  input  logic              bwe_n,
  input  logic [LANES-1:0]  bw_n,
  input  logic [DATA_W-1:0] wdata,
  output cyc_e              s1_kind,
  output logic [ADDR_W-1:0] s1_addr,
  output logic [LANES-1:0]  s1_mask,
  output logic [DATA_W-1:0] s1_wdata
);
  logic [LANES-1:0] mask_c;
  cyc_e             kind_c;

  for (genvar i = 0; i < LANES; i++) begin : g_lane_mask
    assign mask_c[i] = ~gw_n | (~bwe_n & ~bw_n[i]);
  end

  always_comb begin
    if (sleep || !sel)                  kind_c = CYC_IDLE;
    else if (proc_start || mask_c == '0) kind_c = CYC_READ;
    else                                kind_c = CYC_WRITE;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      s1_kind <= CYC_IDLE;
      s1_mask <= '0;
    end else begin
      s1_kind <= kind_c;
      s1_mask <= (kind_c == CYC_WRITE) ? mask_c : '0;
    end
    s1_addr  <= addr;
    s1_wdata <= wdata;
  end

  // R4
  proc_read_chk: assert property (@(posedge clk) disable iff (rst)
    (sel && !sleep && proc_start) |=> (s1_kind == CYC_READ && s1_mask == '0))
    else $error("processor-opened first cycle was not a read");
endmodule

// File: rtl/sbsram_array.sv
module sbsram_array #(
  parameter int ADDR_W = 10,
  parameter int LANES  = 4,
  parameter int LANE_W = 8,
  localparam int DATA_W = LANES * LANE_W,
  localparam int DEPTH  = 1 << ADDR_W
) (
  input  logic              clk,
  input  logic [ADDR_W-1:0] addr,
  input  logic [LANES-1:0]  we,
  input  logic              re,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata
);
  for (genvar i = 0; i < LANES; i++) begin : g_lane_ram
    logic [LANE_W-1:0] mem [DEPTH];
    always_ff @(posedge clk) begin
      if (we[i]) mem[addr] <= wdata[i*LANE_W +: LANE_W];
      if (re)    rdata[i*LANE_W +: LANE_W] <= mem[addr];
    end
  end
endmodule

// File: rtl/sbsram_out_stage.sv
module sbsram_out_stage
  import sbsram_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic sleep,
  input  logic oe_n,
  input  cyc_e s1_kind,
  output logic dq_drive
);
  logic rd_valid_q;

  always_ff @(posedge clk) begin
    if (rst) rd_valid_q <= 1'b0;
    else     rd_valid_q <= (s1_kind == CYC_READ) && !sleep;
  end

  assign dq_drive = rd_valid_q && (s1_kind != CYC_WRITE) && !oe_n;

  // R8
  sleep_release_chk: assert property (@(posedge clk) disable iff (rst)
    sleep |=> !dq_drive)
    else $error("bus driven after sleep edge");
endmodule

// File: rtl/sbsram_model.sv
module sbsram_model
  import sbsram_pkg::*;
#(
  parameter int ADDR_W = 10,
  parameter int LANES  = 4,
  parameter int LANE_W = 8,
  localparam int DATA_W = LANES * LANE_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sleep,
  input  logic              sel,
  input  logic              proc_start,
  input  logic [ADDR_W-1:0] addr,
  input  logic              gw_n,
  input  logic              bwe_n,
  input  logic [LANES-1:0]  bw_n,
  input  logic              oe_n,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] dq_out,
  output logic              dq_drive
);
  cyc_e              s1_kind;
  logic [ADDR_W-1:0] s1_addr;
  logic [LANES-1:0]  s1_mask;
  logic [DATA_W-1:0] s1_wdata;
  logic [LANES-1:0]  lane_we;

  sbsram_in_stage #(.ADDR_W(ADDR_W), .LANES(LANES), .LANE_W(LANE_W)) u_in (
    .clk(clk), .rst(rst), .sleep(sleep), .sel(sel), .proc_start(proc_start),
    .addr(addr), .gw_n(gw_n), .bwe_n(bwe_n), .bw_n(bw_n), .wdata(wdata),
    .s1_kind(s1_kind), .s1_addr(s1_addr), .s1_mask(s1_mask), .s1_wdata(s1_wdata)
  );

  assign lane_we = (s1_kind == CYC_WRITE) ? s1_mask : '0;

  sbsram_array #(.ADDR_W(ADDR_W), .LANES(LANES), .LANE_W(LANE_W)) u_ram (
    .clk(clk), .addr(s1_addr), .we(lane_we), .re(s1_kind == CYC_READ),
    .wdata(s1_wdata), .rdata(dq_out)
  );

  sbsram_out_stage u_out (
    .clk(clk), .rst(rst), .sleep(sleep), .oe_n(oe_n),
    .s1_kind(s1_kind), .dq_drive(dq_drive)
  );

  // R1
  global_write_all_chk: assert property (@(posedge clk) disable iff (rst)
    (sel && !sleep && !proc_start && !gw_n) |=> (lane_we == '1))
    else $error("global write did not enable every lane");

  // R6
  write_release_chk: assert property (@(posedge clk) disable iff (rst)
    (sel && !sleep && !proc_start && !gw_n) |=> !dq_drive)
    else $error("bus driven during write cycle");

  // R5
  read_latency_chk: assert property (@(posedge clk) disable iff (rst)
    dq_drive |-> $past(sel, 2))
    else $error("bus driven without a selected cycle two edges back");
endmodule

// File: tb/sbsram_model_test.sv
module sbsram_model_test;
  localparam int AW    = 10;
  localparam int DEPTH = 1 << AW;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          sleep = 1'b0, sel = 1'b0, proc_start = 1'b0;
  logic [AW-1:0] addr = '0;
  logic          gw_n = 1'b1, bwe_n = 1'b1, oe_n = 1'b0;
  logic [3:0]    bw_n = 4'hF;
  logic [31:0]   wdata = '0;
  logic [31:0]   dq_out;
  logic          dq_drive;

  int checks = 0;
  int fails  = 0;

  logic [31:0]   ref_mem [DEPTH];
  int            e_kind = 0;
  logic [AW-1:0] e_addr = '0;
  logic [3:0]    e_mask = '0;
  logic [31:0]   e_wd = '0;
  bit            e_rdv = 1'b0;
  logic [31:0]   e_rdata = '0;

  always #5 clk = ~clk;

  sbsram_model #(.ADDR_W(AW)) uut (
    .clk(clk), .rst(rst), .sleep(sleep), .sel(sel), .proc_start(proc_start),
    .addr(addr), .gw_n(gw_n), .bwe_n(bwe_n), .bw_n(bw_n), .oe_n(oe_n),
    .wdata(wdata), .dq_out(dq_out), .dq_drive(dq_drive)
  );

  task automatic step(input string tag, input bit slp, input bit sl, input bit ps,
                      input logic [AW-1:0] a, input bit gw, input bit bwe,
                      input logic [3:0] bw, input bit oe, input logic [31:0] wd);
    bit          exp_drv;
    logic [3:0]  m;
    int          k;
    @(negedge clk);
    sleep = slp; sel = sl; proc_start = ps; addr = a;
    gw_n = gw; bwe_n = bwe; bw_n = bw; oe_n = oe; wdata = wd;
    #1;
    exp_drv = e_rdv && (e_kind != 2) && !oe;
    checks++;
    if (dq_drive !== exp_drv) begin
      fails++;
      $display("FAIL %s: dq_drive actual %b expected %b", tag, dq_drive, exp_drv);
    end
    if (exp_drv) begin
      checks++;
      if (dq_out !== e_rdata) begin
        fails++;
        $display("FAIL %s: dq_out actual %h expected %h", tag, dq_out, e_rdata);
      end
    end
    // reference update for the coming edge
    e_rdv = (e_kind == 1) && !slp;
    if (e_kind == 1) e_rdata = ref_mem[e_addr];
    if (e_kind == 2)
      for (int i = 0; i < 4; i++)
        if (e_mask[i]) ref_mem[e_addr][i*8 +: 8] = e_wd[i*8 +: 8];
    m = !gw ? 4'hF : (!bwe ? ~bw : 4'h0);
    if (slp || !sl)          k = 0;
    else if (ps || m == 4'h0) k = 1;
    else                     k = 2;
    e_kind = k; e_addr = a; e_mask = m; e_wd = wd;
  endtask

  task automatic idle(input string tag, input bit oe);
    step(tag, 1'b0, 1'b0, 1'b0, '0, 1'b1, 1'b1, 4'hF, oe, 32'h0);
  endtask
  task automatic rd(input string tag, input logic [AW-1:0] a);
    step(tag, 1'b0, 1'b1, 1'b0, a, 1'b1, 1'b1, 4'hF, 1'b0, $urandom);
  endtask
  task automatic wr(input string tag, input logic [AW-1:0] a, input bit gw,
                    input bit bwe, input logic [3:0] bw, input logic [31:0] d);
    step(tag, 1'b0, 1'b1, 1'b0, a, gw, bwe, bw, 1'b0, d);
  endtask

  initial begin
    void'($urandom(32'd4711));
    // R10: reset state
    repeat (3) begin
      @(negedge clk);
      checks++;
      if (dq_drive !== 1'b0) begin
        fails++;
        $display("FAIL R10: dq_drive actual %b expected 0", dq_drive);
      end
    end
    @(negedge clk); rst = 1'b0;
    idle("R10", 1'b0);
    idle("R10", 1'b0);

    // fill every word with a global write
    for (int a = 0; a < DEPTH; a++)
      wr("R1", a[AW-1:0], 1'b0, 1'b1, 4'hF, a * 32'h9E3779B1);
    idle("R1", 1'b0); idle("R1", 1'b0);

    // R1 with byte controls asserted, then R9 read-after-write
    wr("R1", 10'd5, 1'b0, 1'b0, 4'hA, 32'hCAFE_F00D);
    rd("R9", 10'd5);
    idle("R9", 1'b0); idle("R9", 1'b0);

    // R2: every nonzero lane mask
    for (int m = 1; m < 16; m++) begin
      wr("R2", 10'(200 + m), 1'b1, 1'b0, ~m[3:0], 32'hA5C3_0FF0 ^ m);
      rd("R2", 10'(200 + m));
      idle("R2", 1'b0); idle("R2", 1'b0);
    end

    // R3: non-write encodings
    wr("R3", 10'd300, 1'b1, 1'b1, 4'h0, 32'h1111_2222);
    wr("R3", 10'd300, 1'b1, 1'b0, 4'hF, 32'h3333_4444);
    rd("R3", 10'd300);
    idle("R3", 1'b0); idle("R3", 1'b0);

    // R4: processor-opened first cycle ignores global write
    step("R4", 1'b0, 1'b1, 1'b1, 10'd301, 1'b0, 1'b0, 4'h0, 1'b0, 32'hDEAD_BEEF);
    idle("R4", 1'b0); idle("R4", 1'b0);
    rd("R4", 10'd301);
    idle("R4", 1'b0); idle("R4", 1'b0);

    // R5: wrapped four-word burst, then held address
    rd("R5", 10'h42); rd("R5", 10'h43); rd("R5", 10'h40); rd("R5", 10'h41);
    rd("R5", 10'h41); rd("R5", 10'h41); rd("R5", 10'h42);
    idle("R5", 1'b0); idle("R5", 1'b0);

    // R6: write right after read releases the bus
    rd("R6", 10'h50);
    wr("R6", 10'h51, 1'b1, 1'b0, 4'h0, 32'h7777_8888);
    idle("R6", 1'b0); idle("R6", 1'b0);

    // R7: output enable high, then deselect
    rd("R7", 10'h52);
    idle("R7", 1'b0);
    idle("R7", 1'b1);
    idle("R7", 1'b0);

    // R8: sleep ignores writes, bus stays released after exit
    idle("R8", 1'b0);
    repeat (3) step("R8", 1'b1, 1'b1, 1'b0, 10'h60, 1'b0, 1'b1, 4'hF, 1'b0, 32'h0BAD_0BAD);
    idle("R8", 1'b0); idle("R8", 1'b0);
    rd("R8", 10'h60);
    idle("R8", 1'b0); idle("R8", 1'b0);

    // constrained random mix over a narrow window
    begin
      bit prev_sel = 1'b0;
      bit in_sleep = 1'b0;
      for (int n = 0; n < 800; n++) begin
        int r = $urandom % 100;
        bit s;
        if (in_sleep) in_sleep = (r % 4) != 0;
        else          in_sleep = !prev_sel && (r < 6);
        s = ($urandom % 4) != 0;
        step(in_sleep ? "R8" : "R5", in_sleep, s, ($urandom % 6) == 0,
             AW'($urandom % 16), ($urandom % 8) != 0, $urandom % 2,
             4'($urandom), ($urandom % 8) == 0, $urandom);
        prev_sel = s || in_sleep;
      end
    end
    idle("R7", 1'b0); idle("R7", 1'b0);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #1_000_000;
    fails++;
    $display("FAIL watchdog: run did not finish, actual hung expected done");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule